// File: doc/BRIEF.md
# Gap-Coded Tag Block Write Sequencer

This block programs one 32-bit word into a numbered block of a rewritable low-frequency tag by keying the reader's carrier field. A write begins with a long field-on period that powers the tag, then a short field-off start gap. After that, every command bit is sent as a field-on interval whose length carries the bit value, and each is followed by a fixed field-off gap. Once the last bit's gap ends, the field is held on while the tag programs its memory. The field is then dropped and a completion pulse is raised.

The bit stream is a fixed 3-bit header, then the data word from its most significant bit down, then the 3-bit block number from its most significant bit down. The header is a one, a zero that selects page 0, and a zero that leaves the block unlocked. All timing is counted on a one-microsecond tick input. The two long waits are counted as a number of milliseconds, each built from a parameterised number of ticks. Every duration is a parameter, and the defaults give 150 ms of power-up, a 250 µs start gap, 144 µs for a zero, 400 µs for a one, a 160 µs bit gap and 20 ms of programming.

Top module: `tag_block_writer`

## Requirements
- R1: After reset, and after a reset applied in the middle of a write, `field_on`, `busy` and `done` are all 0.
- R2: A `start` pulse while idle captures `wr_data` and `wr_block`. On the next clock `field_on` and `busy` are 1. Later changes on `wr_data` and `wr_block` do not alter the write in progress.
- R3: The first field-on interval lasts POWER_MS × US_PER_MS ticks (default 150 ms).
- R4: The power-up interval is followed by a field-off start gap of START_GAP_US ticks (default 250 µs).
- R5: Each bit is sent as field on for ZERO_US ticks for a 0 (default 144) or ONE_US ticks for a 1 (default 400), followed by field off for GAP_US ticks (default 160).
- R6: Exactly 38 bits are sent, in this order: 1, 0, 0, then `wr_data` bit 31 down to bit 0, then `wr_block` bit 2 down to bit 0.
- R7: After the last bit's gap, the field is on for PROG_MS × US_PER_MS ticks (default 20 ms) and is then switched off.
- R8: `done` is high for exactly one cycle, in the first cycle with the field off after the programming hold. `busy` is 0 on the following cycle.
- R9: A `start` pulse while `busy` is 1 is ignored, and its data and block number never reach the field.
- R10: Timing advances only on cycles where `tick_us` is 1. While busy, `field_on` changes only on the clock edge after a cycle that has `tick_us` high.
- R11: While idle, the field stays off whatever `tick_us` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe marking each microsecond |
| start | input | 1 | Begin a write (taken only when idle) |
| wr_data | input | DW | Word to write, sent MSB first |
| wr_block | input | AW | Target block number, sent MSB first |
| field_on | output | 1 | Reader carrier enable |
| busy | output | 1 | A write sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Writes are tried with a mixed word against a mid-range block, with all zeros against block 0, and with all ones against block 7. The zeros and ones cases show that each bit width depends on its own bit value and not on a neighbour's. A word with only its two end bits set, aimed at block 2, shows that the data edges sit at the right places between the header and the block bits. Because ticks are spaced one, two and three clocks apart, the bench can tell time counted in ticks from time counted in clocks, and a second start with a different word in the middle of each write shows whether a busy start leaks into the stream.

// File: rtl/tag_block_writer.sv
module tag_block_writer #(
  parameter int US_PER_MS    = 1000,
  parameter int POWER_MS     = 150,
  parameter int PROG_MS      = 20,
  parameter int START_GAP_US = 250,
  parameter int GAP_US       = 160,
  parameter int ZERO_US      = 144,
  parameter int ONE_US       = 400,
  parameter int DW           = 32,
  parameter int AW           = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_us,
  input  logic          start,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] wr_block,
  output logic          field_on,
  output logic          busy,
  output logic          done
);
  localparam int NBITS = 3 + DW + AW;
  localparam int UMAX1 = (US_PER_MS > START_GAP_US) ? US_PER_MS : START_GAP_US;
  localparam int UMAX2 = (GAP_US > ZERO_US) ? GAP_US : ZERO_US;
  localparam int UMAX3 = (UMAX1 > UMAX2) ? UMAX1 : UMAX2;
  localparam int UMAX  = (UMAX3 > ONE_US) ? UMAX3 : ONE_US;
  localparam int UW    = $clog2(UMAX + 1);
  localparam int MMAX  = (POWER_MS > PROG_MS) ? POWER_MS : PROG_MS;
  localparam int MW    = $clog2(MMAX + 1);
  localparam int IW    = $clog2(NBITS + 1);

  typedef enum logic [2:0] {S_IDLE, S_PWR, S_SGAP, S_ON, S_OFF, S_PROG, S_DONE} st_t;

  st_t              st;
  logic [NBITS-1:0] sh;
  logic [IW-1:0]    idx;
  logic [UW-1:0]    us_cnt, us_lim;
  logic [MW-1:0]    ms_cnt, ms_lim;
  logic             us_end, ms_end, long_seg, seg_end;

  always_comb begin
    case (st)
      S_PWR, S_PROG: us_lim = UW'(US_PER_MS);
      S_SGAP:        us_lim = UW'(START_GAP_US);
      S_ON:          us_lim = sh[NBITS-1] ? UW'(ONE_US) : UW'(ZERO_US);
      S_OFF:         us_lim = UW'(GAP_US);
      default:       us_lim = UW'(1);
    endcase
  end

  assign long_seg = (st == S_PWR) || (st == S_PROG);
  assign ms_lim   = (st == S_PWR) ? MW'(POWER_MS) : MW'(PROG_MS);
  assign us_end   = tick_us && (us_cnt == us_lim - 1'b1);
  assign ms_end   = us_end && (ms_cnt == ms_lim - 1'b1);
  assign seg_end  = long_seg ? ms_end : us_end;
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= '0;
      idx      <= '0;
      us_cnt   <= '0;
      ms_cnt   <= '0;
      field_on <= 1'b0;
    end else if (st == S_IDLE) begin
      us_cnt <= '0;
      ms_cnt <= '0;
      if (start) begin
        sh       <= {3'b100, wr_data, wr_block};
        idx      <= '0;
        field_on <= 1'b1;
        st       <= S_PWR;
      end
    end else if (st == S_DONE) begin
      st <= S_IDLE;
    end else begin
      if (tick_us) begin
        us_cnt <= us_end ? '0 : us_cnt + 1'b1;
        if (long_seg && us_end) ms_cnt <= ms_end ? '0 : ms_cnt + 1'b1;
      end
      if (seg_end) begin
        case (st)
          S_PWR:  begin st <= S_SGAP; field_on <= 1'b0; end
          S_SGAP: begin st <= S_ON;   field_on <= 1'b1; end
          S_ON:   begin st <= S_OFF;  field_on <= 1'b0; end
          S_OFF: begin
            field_on <= 1'b1;
            if (idx == IW'(NBITS - 1)) st <= S_PROG;
            else begin
              st  <= S_ON;
              idx <= idx + 1'b1;
              sh  <= sh << 1;
            end
          end
          S_PROG: begin st <= S_DONE; field_on <= 1'b0; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module tag_block_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_us,
  input logic start,
  input logic field_on,
  input logic busy,
  input logic done
);
  // R8
  done_field_off_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !field_on);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && !busy));
  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (field_on && busy));
  // R10
  tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !tick_us) |=> $stable(field_on));
  // R11
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !field_on);
endmodule

bind tag_block_writer tag_block_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(start),
  .field_on(field_on), .busy(busy), .done(done)
);

// File: tb/tag_block_writer_bench.sv
module tag_block_writer_bench;
  localparam int USMS = 8, PMS = 3, GMS = 2, SG = 5, BG = 3, Z = 2, O = 6;
  localparam int NRUN = 2 + 2 * 38 + 1;

  logic clk = 0, rst_n = 0, tick_us = 0, start = 0;
  logic [31:0] wr_data = '0;
  logic [2:0]  wr_block = '0;
  logic field_on, busy, done;
  int checks = 0, fails = 0, k = 1, tcnt = 0;

  int exp_len [0:NRUN-1];
  logic exp_lvl [0:NRUN-1];
  int got_len [0:127];
  logic got_lvl [0:127];
  int ne, ng;

  localparam logic [36:0] VEC [4] = '{
    {2'd1, 3'd5, 32'hA5C3_0F96},
    {2'd1, 3'd0, 32'h0000_0000},
    {2'd2, 3'd7, 32'hFFFF_FFFF},
    {2'd3, 3'd2, 32'h8000_0001}
  };

  always #2.5 clk = ~clk;

  tag_block_writer #(.US_PER_MS(USMS), .POWER_MS(PMS), .PROG_MS(GMS), .START_GAP_US(SG),
    .GAP_US(BG), .ZERO_US(Z), .ONE_US(O)) u_tag_block_writer (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(start), .wr_data(wr_data),
    .wr_block(wr_block), .field_on(field_on), .busy(busy), .done(done));

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % k;
    tick_us = (tcnt == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push_exp(input logic lv, input int len);
    exp_lvl[ne] = lv; exp_len[ne] = len; ne++;
  endtask

  task automatic do_write(input logic [31:0] d, input logic [2:0] b, input int kk);
    logic [37:0] cmd;
    logic prev;
    int cnt, cyc;
    bit got;
    k = kk;
    cmd = {3'b100, d, b};
    ne = 0;
    push_exp(1, PMS * USMS * kk);
    push_exp(0, SG * kk);
    for (int i = 37; i >= 0; i--) begin
      push_exp(1, (cmd[i] ? O : Z) * kk);
      push_exp(0, BG * kk);
    end
    push_exp(1, GMS * USMS * kk);

    @(negedge clk); start = 1; wr_data = d; wr_block = b;
    @(negedge clk); start = 0; wr_data = ~d; wr_block = ~b;
    chk(field_on && busy, "R2 launch", {field_on, busy}, 3);
    prev = field_on; cnt = 1; ng = 0; cyc = 0; got = 0;
    while (!got && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 40) begin start = 1; wr_data = 32'h1234_5678; wr_block = 3'd6; end
      if (cyc == 41) start = 0;
      if (done) begin
        chk(!field_on, "R8 field off at done", field_on, 0);
        got_lvl[ng] = prev; got_len[ng] = cnt; ng++;
        got = 1;
      end else if (field_on != prev) begin
        got_lvl[ng] = prev; got_len[ng] = cnt; ng++;
        prev = field_on; cnt = 1;
        if (ng > 120) cyc = 20000;
      end else cnt++;
    end
    chk(got, "R8 done seen (write watchdog)", got, 1);
    chk(ng == NRUN, "R6 run count", ng, NRUN);
    if (ng == NRUN) begin
      for (int j = 0; j < NRUN; j++) begin
        string tag;
        if (j == 0) tag = "R3 power-up";
        else if (j == 1) tag = "R4 start gap";
        else if (j == NRUN - 1) tag = "R7 programming";
        else if (got_lvl[j]) tag = "R5 R6 R9 bit on-time";
        else tag = "R5 bit gap";
        if (kk > 1) tag = {tag, " R10"};
        chk(got_lvl[j] == exp_lvl[j], {tag, " level"}, got_lvl[j], exp_lvl[j]);
        if (j == 0)
          chk(got_len[j] <= exp_len[j] && got_len[j] > exp_len[j] - kk, {tag, " length"},
              got_len[j], exp_len[j]);
        else
          chk(got_len[j] == exp_len[j], {tag, " length"}, got_len[j], exp_len[j]);
      end
    end
    @(negedge clk);
    chk(!done && !busy, "R8 done single, busy cleared", {done, busy}, 0);
    repeat (20) @(negedge clk);
    chk(!field_on && !busy, "R11 idle field off", field_on, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!field_on && !busy && !done, "R1 reset state", {field_on, busy, done}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!field_on && !busy, "R11 idle after reset", {field_on, busy}, 0);

    for (int v = 0; v < 4; v++)
      do_write(VEC[v][31:0], VEC[v][34:32], int'(VEC[v][36:35]));

    k = 1;
    @(negedge clk); start = 1; wr_data = 32'hDEAD_BEEF; wr_block = 3'd1;
    @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    chk(field_on && busy, "R2 mid-write active", {field_on, busy}, 3);
    rst_n = 0;
    @(negedge clk);
    chk(!field_on && !busy && !done, "R1 reset mid-write", {field_on, busy, done}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!field_on && !busy, "R1 stays idle", {field_on, busy}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule